// File: doc/BRIEF.md
# PWM Sample Queue with Watermark and Error Flags

This block is a small first-in first-out queue of duty samples placed between a 32-bit register write path and a pulse-width modulation core. Each write carries a 32-bit word. One 16-bit half of that word is selected, its two bytes are optionally exchanged, and the result is appended to a four-entry store. The PWM core reads the oldest entry through `sample_out` and removes it with a one-cycle `pop` pulse.

The block keeps a status vector. The low three bits give the number of stored words. Four sticky flags sit above them:
- a watermark flag, raised while enough slots are free;
- a rollover flag and a compare flag, which capture event pulses from the PWM core;
- an error flag, raised by a write that arrives while the queue is full.

Software clears any flag by writing a one to its position. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `pwm_sample_fifo`

## Requirements
- R1: While reset is held, `status` reads all zeros and `sample_out` reads zero.
- R2: `status[2:0]` gives the stored word count, 0 to 4. `sample_out` shows the oldest stored word, or zero when the queue is empty. Each pop removes the oldest word, so words come out in the order they were written.
- R3: With `hw_sel` = 0 the sample is taken from `wr_data[15:0]`. With `hw_sel` = 1 it is taken from `wr_data[31:16]`.
- R4: With `byte_rev` = 1 the two bytes of the selected half are exchanged before storage, so the stored value is {half[7:0], half[15:8]}. With `byte_rev` = 0 the half is stored unchanged.
- R5: A write that arrives while four words are stored is discarded. The count stays 4, and the stored words and their order are unchanged.
- R6: A write that arrives while the queue is full sets `status[6]` in the following cycle. The bit stays set until it is cleared.
- R7: `status[3]` is set in the cycle after any cycle in which the number of free slots (4 minus the count) is at least `wmark`+1. For example, `wmark`=1 requires 2 or more free slots.
- R8: A pulse on `rov_evt` sets `status[4]`, and a pulse on `cmp_evt` sets `status[5]`, in the following cycle. Each bit stays set until it is cleared.
- R9: A cycle with `st_wr`=1 clears each flag in `status[6:3]` whose bit in `st_mask` is 1. A set condition in the same cycle wins over the clear. Mask bits that are 0, and mask bits 2:0, have no effect.
- R10: A write and a pop in the same cycle, with a count between 1 and 3, leave the count unchanged. The written word goes to the tail and the oldest word is removed.
- R11: A pop while the queue is empty is ignored: the count stays 0 and `sample_out` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the sample word |
| wr_data | input | 32 | Write data bus |
| hw_sel | input | 1 | Selects the upper half of `wr_data` when 1 |
| byte_rev | input | 1 | Exchanges the two bytes of the selected half when 1 |
| wmark | input | 2 | Watermark threshold: flag raised at `wmark`+1 or more free slots |
| pop | input | 1 | Removes the oldest sample |
| rov_evt | input | 1 | Rollover event pulse from the PWM core |
| cmp_evt | input | 1 | Compare event pulse from the PWM core |
| st_wr | input | 1 | Status write strobe (write-one-to-clear) |
| st_mask | input | 7 | Flags to clear, by bit position |
| sample_out | output | 16 | Oldest stored sample |
| status | output | 7 | {error, compare, rollover, watermark, count[2:0]} |

## Verification
The hardest situation to reach is the collision between a flag's set condition and its clear in the same cycle. For the error flag, this is a full-queue write landing in the same cycle as a status clear. For the watermark flag, it is a clear issued while the free-slot condition still holds.

The bench fills the queue to every level from 0 to 4 under every `wmark` setting. At each point it issues a clear and compares the surviving flag with the arithmetic free-slot test. It then repeats a full-queue write together with a clear, to confirm that the set wins.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int SAMPLE_W = 16;
  localparam int BUS_W    = 32;
  localparam int STAT_W   = 7;
  localparam int F_WM     = 3;
  localparam int F_ROV    = 4;
  localparam int F_CMP    = 5;
  localparam int F_ERR    = 6;
  localparam int NFLAGS   = 4;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sfifo_shaper.sv
module sfifo_shaper #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] bus_word,
  input  logic            hw_sel,
  input  logic            byte_rev,
  output logic [DW-1:0]   sample
);
  localparam int NBYTES = DW / 8;

  logic [DW-1:0] half;
  logic [DW-1:0] rev;

  assign half = hw_sel ? bus_word[2*DW-1:DW] : bus_word[DW-1:0];

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign rev[8*b +: 8] = half[8*(NBYTES-1-b) +: 8];
  end

  assign sample = byte_rev ? rev : half;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             push_ok, pop_ok, upd_en;

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign upd_en  = push_ok || pop_ok;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    if (push_ok && !pop_ok)      level_d = level_q + 1'b1;
    else if (pop_ok && !push_ok) level_d = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (upd_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= din;
  end

  assign dout  = empty ? '0 : mem[rd_ptr_q];
  assign level = level_q;

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));
  a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(dout)));
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> (level_q == $past(level_q)));
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int WM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic [WM_W-1:0]   wmark,
  input  logic              wr_full,
  input  logic              rov_evt,
  input  logic              cmp_evt,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] st_mask,
  output logic [STAT_W-1:0] status
);
  localparam int CW = (LVL_W > WM_W ? LVL_W : WM_W) + 1;

  logic [NFLAGS-1:0] flag_q, flag_d, set_v, clr_v;
  logic [CW-1:0]     free_slots, need_slots;
  logic              wm_cond;

  assign free_slots = CW'(DEPTH) - CW'(level);
  assign need_slots = CW'(wmark) + 1'b1;
  assign wm_cond    = free_slots >= need_slots;

  assign set_v = {wr_full, cmp_evt, rov_evt, wm_cond};

  for (genvar k = 0; k < NFLAGS; k++) begin : g_flag
    assign clr_v[k]  = st_wr && st_mask[F_WM + k];
    assign flag_d[k] = set_v[k] || (flag_q[k] && !clr_v[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign status = {flag_q, level};

  a_r7_wm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wm_cond |=> status[F_WM]);
  a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> status[F_ERR]);
  a_r8_rov_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rov_evt |=> status[F_ROV]);
  a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_mask[F_ERR] && !wr_full) |=> !status[F_ERR]);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[F_ERR] && !(st_wr && st_mask[F_ERR])) |=> status[F_ERR]);
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WM_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic                hw_sel,
  input  logic                byte_rev,
  input  logic [WM_W-1:0]     wmark,
  input  logic                pop,
  input  logic                rov_evt,
  input  logic                cmp_evt,
  input  logic                st_wr,
  input  logic [STAT_W-1:0]   st_mask,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [STAT_W-1:0]   status
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic                rst_int_n;
  logic [SAMPLE_W-1:0] shaped;
  logic [LVL_W-1:0]    level;
  logic                full, empty;

  sfifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sfifo_shaper #(.DW(SAMPLE_W)) u_shape (
    .bus_word (wr_data),
    .hw_sel   (hw_sel),
    .byte_rev (byte_rev),
    .sample   (shaped)
  );

  sfifo_store #(.DW(SAMPLE_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (wr_en),
    .pop   (pop),
    .din   (shaped),
    .dout  (sample_out),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  sfifo_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W), .WM_W(WM_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .level   (level),
    .wmark   (wmark),
    .wr_full (wr_en && full),
    .rov_evt (rov_evt),
    .cmp_evt (cmp_evt),
    .st_wr   (st_wr),
    .st_mask (st_mask),
    .status  (status)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_int_n |=> (status == '0 || !rst_int_n));
endmodule

// File: tb/sim_pwm_sample_fifo.sv
module sim_pwm_sample_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, hw_sel, byte_rev, pop, rov_evt, cmp_evt, st_wr;
  logic [31:0] wr_data;
  logic [1:0]  wmark;
  logic [6:0]  st_mask;
  logic [15:0] sample_out;
  logic [6:0]  status;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] q [4];
  int          n_m;
  bit          err_m, rov_m, cmp_m;

  always #5 clk = ~clk;

  pwm_sample_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .hw_sel(hw_sel),
    .byte_rev(byte_rev), .wmark(wmark), .pop(pop), .rov_evt(rov_evt), .cmp_evt(cmp_evt),
    .st_wr(st_wr), .st_mask(st_mask), .sample_out(sample_out), .status(status)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] shape(logic [31:0] w, bit h, bit b);
    logic [15:0] x;
    x = h ? w[31:16] : w[15:0];
    return b ? {x[7:0], x[15:8]} : x;
  endfunction

  // one clock edge with the given stimulus; model updated; sampled at next negedge
  task automatic step(bit wr, logic [31:0] d, bit h, bit b, bit p,
                      bit clr, logic [6:0] m, bit rv, bit cp);
    bit full_w;
    wr_en = wr; wr_data = d; hw_sel = h; byte_rev = b; pop = p;
    st_wr = clr; st_mask = m; rov_evt = rv; cmp_evt = cp;
    @(negedge clk);
    full_w = wr && (n_m == 4);
    if (p && n_m > 0) begin
      for (int i = 0; i < 3; i++) q[i] = q[i+1];
      n_m--;
    end
    if (wr && !full_w) begin
      q[n_m] = shape(d, h, b);
      n_m++;
    end
    err_m = full_w || (err_m && !(clr && m[6]));
    rov_m = rv || (rov_m && !(clr && m[4]));
    cmp_m = cp || (cmp_m && !(clr && m[5]));
    wr_en = 0; pop = 0; st_wr = 0; st_mask = '0; rov_evt = 0; cmp_evt = 0;
  endtask

  task automatic drain_check(string tag);
    while (n_m > 0) begin
      chk(tag, sample_out, q[0]);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    end
    chk(tag, status[2:0], 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; hw_sel = 0; byte_rev = 0; wmark = 2'd1;
    pop = 0; rov_evt = 0; cmp_evt = 0; st_wr = 0; st_mask = 0;
    n_m = 0; err_m = 0; rov_m = 0; cmp_m = 0;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 sample", sample_out, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 count", status[2:0], 0);

    // R3/R4: every swap combination on several words
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] w;
        w = 32'h1234_ABCD ^ (32'h0F1E_2D3C * k);
        step(1, w, c[0], c[1], 0, 0, 0, 0, 0);
        chk("R3 R4 shaped", sample_out, shape(w, c[0], c[1]));
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
      end
    end

    // R7 + R2: every watermark at every fill level
    for (int wm = 0; wm < 4; wm++) begin
      for (int n = 0; n <= 4; n++) begin
        wmark = wm[1:0];
        for (int i = 0; i < n; i++)
          step(1, 32'h5A00_0000 + 32'(wm * 16 + n * 4 + i), i[0], i[1], 0, 0, 0, 0, 0);
        chk("R2 count", status[2:0], n);
        step(0, 0, 0, 0, 0, 1, 7'h08, 0, 0);
        chk("R7 watermark", status[3], ((4 - n) >= (wm + 1)));
        drain_check("R2 order");
      end
    end
    wmark = 2'd1;

    // R5/R6: write while full
    for (int i = 0; i < 4; i++) step(1, 32'(16'hC000 + i), 0, 0, 0, 0, 0, 0, 0);
    chk("R6 no error yet", status[6], 0);
    step(1, 32'h0000_FFFF, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 count stays", status[2:0], 4);
    chk("R6 error set", status[6], 1);
    chk("R5 head kept", sample_out, 16'hC000);
    drain_check("R5 contents");
    chk("R6 sticky", status[6], err_m);
    step(0, 0, 0, 0, 0, 1, 7'h07, 0, 0);
    chk("R9 low mask no effect", status[6:4], {err_m, cmp_m, rov_m});
    step(0, 0, 0, 0, 0, 1, 7'h40, 0, 0);
    chk("R9 error cleared", status[6], 0);
    for (int i = 0; i < 4; i++) step(1, 32'(i), 0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h77, 0, 0, 0, 1, 7'h40, 0, 0);
    chk("R9 set wins", status[6], 1);
    drain_check("R5 after collide");
    step(0, 0, 0, 0, 0, 1, 7'h40, 0, 0);

    // R8/R9: event flags
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 rollover", status[6:4], 3'b001);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 compare", status[6:4], 3'b011);
    step(0, 0, 0, 0, 0, 1, 7'h20, 0, 0);
    chk("R9 compare only cleared", status[6:4], 3'b001);
    step(0, 0, 0, 0, 0, 1, 7'h10, 1, 0);
    chk("R9 rollover set wins", status[6:4], 3'b001);
    step(0, 0, 0, 0, 0, 1, 7'h30, 0, 0);
    chk("R9 both cleared", status[6:4], 3'b000);

    // R10: push and pop together at levels 1..3
    for (int lv = 1; lv <= 3; lv++) begin
      for (int i = 0; i < lv; i++) step(1, 32'(16'hA000 + lv * 16 + i), 0, 0, 0, 0, 0, 0, 0);
      step(1, 32'(16'hB000 + lv), 0, 1, 1, 0, 0, 0, 0);
      chk("R10 count held", status[2:0], lv);
      drain_check("R10 order");
    end

    // R11: pop while empty
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11 count", status[2:0], 0);
    chk("R11 sample", sample_out, 0);
    step(1, 32'h0000_4321, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 next write ok", sample_out, 16'h4321);
    drain_check("R11 drain");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule